// File: doc/BRIEF.md
# Battery Presence Probe and Timeout Recovery Sequencer

This block sits beside the main charge state machine of a single-cell linear charger. Once the main machine has finished a charge, or has stopped on a safety timeout, the sequencer watches the battery comparators. When the cell voltage sags under the recharge threshold, it runs a two-window probe. In the first window a small sink current pulls on the output. In the second window the precharge source pushes on it. The second push can also wake a pack whose protector has opened. Comparator levels are taken only on the final millisecond tick of each window.

If either test shows a real cell, the block pulses `present_o` so the main machine starts a fresh cycle. If both tests point to an empty terminal, it pulses `absent_o` and waits. When the output voltage decays again, it probes again, so the pin swings between the low threshold and the regulation voltage indefinitely. A timeout fault is recovered in one of two ways, chosen by the battery level when the fault arrives. A charge-enable rising edge or a reset clears everything at once.

Top module: `bat_probe_seq`

## Requirements
- R1: After reset all three current enables, `fault_o`, `present_o` and `absent_o` are low.
- R2: When idle with `done_i` high and `bat_above_rch_i` low, `det_en_o` rises on the next clock edge.
- R3: The sink window lasts `WIN_TICKS` ticks of `ms_tick_i`. If `bat_below_lowv_i` is low on its last tick, `present_o` pulses for one cycle and all enables drop.
- R4: If `bat_below_lowv_i` is high on the last sink tick, `pre_en_o` replaces `det_en_o` for a second window of `WIN_TICKS` ticks. If `bat_above_rch_i` is low on its last tick, `present_o` pulses.
- R5: If `bat_above_rch_i` is high on the last precharge tick, `absent_o` pulses for one cycle and no enable is on. A new sink window then starts once `bat_above_rch_i` goes low.
- R6: A `tmr_fault_i` pulse while `bat_above_rch_i` is high raises `fault_o` with no current enabled. When `bat_above_rch_i` goes low, `fault_o` clears and a sink window starts.
- R7: A `tmr_fault_i` pulse while `bat_above_rch_i` is low raises `fault_o` and `flt_en_o`. `flt_en_o` stays on while the level stays low and drops when it rises, after which R6 recovery applies.
- R8: A rising edge of `chg_en_i`, or reset, returns the block to idle from any state, with `fault_o` and all enables low on the next cycle.
- R9: At most one of `det_en_o`, `pre_en_o`, `flt_en_o` is high in any cycle, and `present_o` and `absent_o` never pulse together.
- R10: Comparator levels in a window before its last tick have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| chg_en_i | input | 1 | Charge enable level, active high; a rising edge clears the block |
| done_i | input | 1 | Main machine is in the charge-complete state |
| tmr_fault_i | input | 1 | One-cycle pulse: safety timer expired |
| bat_above_rch_i | input | 1 | Comparator: battery above the recharge threshold |
| bat_below_lowv_i | input | 1 | Comparator: battery below the precharge threshold |
| det_en_o | output | 1 | Enable for the small sink (detect) current |
| pre_en_o | output | 1 | Enable for the precharge current |
| flt_en_o | output | 1 | Enable for the fault-recovery current |
| fault_o | output | 1 | Timeout fault held |
| present_o | output | 1 | One-cycle pulse: battery found, start a new cycle |
| absent_o | output | 1 | One-cycle pulse: no battery found |

## Verification
The embedded properties check on every cycle that the three current enables are mutually exclusive and that the two result pulses never coincide. They also check that a precharge window is always entered straight from a sink window, that the fault current never runs without a held fault, and that a clear event leaves the block idle. Whether each window lasts exactly the right number of ticks, and whether only the last-tick comparator value decides the outcome, can only be shown by the bench's scenarios against its behavioural model. The same applies to the absent-then-reprobe loop and to both timeout recovery branches.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_DETECT   = 3'd1,
    S_PRECHG   = 3'd2,
    S_REARM    = 3'd3,
    S_FLT_LOW  = 3'd4,
    S_FLT_WAIT = 3'd5
  } seq_state_e;

  // Fault entry branch chosen by the battery level at timeout.
  function automatic seq_state_e fault_entry(input logic above_rch);
    return above_rch ? S_FLT_WAIT : S_FLT_LOW;
  endfunction
endpackage

// File: rtl/bps_window_timer.sv
module bps_window_timer #(
  parameter int unsigned WIN_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;

  function automatic logic on_final(input logic [CW-1:0] c);
    return c == LAST_CNT;
  endfunction

  assign last_o = run_i && tick_i && on_final(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  // R3: the tick count never passes the final tick of a window
  a_r3_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/bps_clear_gen.sv
module bps_clear_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic clr_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  assign clr_o = en_i && !en_q;
endmodule

// File: rtl/bat_probe_seq.sv
module bat_probe_seq
  import bps_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick_i,
  input  logic chg_en_i,
  input  logic done_i,
  input  logic tmr_fault_i,
  input  logic bat_above_rch_i,
  input  logic bat_below_lowv_i,
  output logic det_en_o,
  output logic pre_en_o,
  output logic flt_en_o,
  output logic fault_o,
  output logic present_o,
  output logic absent_o
);
  seq_state_e state_q, state_d;
  logic       present_d, absent_d;
  logic       in_window;
  logic       win_end;
  logic       clr_evt;

  assign in_window = (state_q == S_DETECT) || (state_q == S_PRECHG);

  bps_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (in_window),
    .tick_i (ms_tick_i),
    .last_o (win_end)
  );

  bps_clear_gen u_clear (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (chg_en_i),
    .clr_o (clr_evt)
  );

  always_comb begin
    state_d   = state_q;
    present_d = 1'b0;
    absent_d  = 1'b0;
    if (clr_evt) begin
      state_d = S_IDLE;
    end else if (tmr_fault_i) begin
      state_d = fault_entry(bat_above_rch_i);
    end else begin
      unique case (state_q)
        S_IDLE:
          if (done_i && !bat_above_rch_i) state_d = S_DETECT;
        S_DETECT:
          if (win_end) begin
            if (bat_below_lowv_i) state_d = S_PRECHG;
            else begin
              state_d   = S_IDLE;
              present_d = 1'b1;
            end
          end
        S_PRECHG:
          if (win_end) begin
            if (bat_above_rch_i) begin
              state_d  = S_REARM;
              absent_d = 1'b1;
            end else begin
              state_d   = S_IDLE;
              present_d = 1'b1;
            end
          end
        S_REARM, S_FLT_WAIT:
          if (!bat_above_rch_i) state_d = S_DETECT;
        S_FLT_LOW:
          if (bat_above_rch_i) state_d = S_FLT_WAIT;
        default:
          state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      present_o <= 1'b0;
      absent_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      present_o <= present_d;
      absent_o  <= absent_d;
    end
  end

  assign det_en_o = (state_q == S_DETECT);
  assign pre_en_o = (state_q == S_PRECHG);
  assign flt_en_o = (state_q == S_FLT_LOW);
  assign fault_o  = (state_q == S_FLT_LOW) || (state_q == S_FLT_WAIT);

  // R9: current sources never overlap
  a_r9_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({det_en_o, pre_en_o, flt_en_o}));
  // R9: a probe reports one verdict only
  a_r9_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(present_o && absent_o));
  // R4: the precharge window only follows a sink window
  a_r4_pre_follows_det: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_en_o) |-> $past(det_en_o));
  // R7: fault current only runs while a fault is held
  a_r7_flt_current_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_en_o |-> fault_o);
  // R8: a clear event leaves the block idle
  a_r8_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (!fault_o && !det_en_o && !pre_en_o && !flt_en_o));
  // R3: a verdict pulse leaves no probe current running
  a_r3_verdict_stops_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (present_o || absent_o) |-> (!det_en_o && !pre_en_o));
endmodule

// File: tb/bat_probe_seq_tb_top.sv
`timescale 1ns/1ps
module bat_probe_seq_tb_top;
  localparam int WIN = 6;
  localparam int TDIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, chg_en = 1'b0, done = 1'b0, tfault = 1'b0;
  logic above = 1'b0, below = 1'b0;
  logic det_en, pre_en, flt_en, fault, present, absent;

  always #4 clk = ~clk;

  bat_probe_seq #(.WIN_TICKS(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .chg_en_i(chg_en),
    .done_i(done), .tmr_fault_i(tfault), .bat_above_rch_i(above),
    .bat_below_lowv_i(below), .det_en_o(det_en), .pre_en_o(pre_en),
    .flt_en_o(flt_en), .fault_o(fault), .present_o(present), .absent_o(absent)
  );

  int compared = 0, mismatched = 0;
  int seen_present = 0, seen_absent = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle,1 sink,2 push,3 rearm,4 fault-low,5 fault-wait
  int m_st = 0, m_ms = 0;
  bit m_prev_en = 0, m_pres = 0, m_abs = 0;

  always @(posedge clk) begin
    m_pres = 0; m_abs = 0;
    if (!rst_n) begin
      m_st = 0; m_ms = 0; m_prev_en = 0;
    end else begin
      if (chg_en && !m_prev_en) begin
        m_st = 0; m_ms = 0;
      end else if (tfault) begin
        m_st = above ? 5 : 4; m_ms = 0;
      end else if (m_st == 0) begin
        if (done && !above) begin m_st = 1; m_ms = 0; end
      end else if (m_st == 1 || m_st == 2) begin
        if (ms_tick) begin
          m_ms++;
          if (m_ms == WIN) begin
            m_ms = 0;
            if (m_st == 1 && below) m_st = 2;
            else if (m_st == 2 && above) begin m_st = 3; m_abs = 1; end
            else begin m_st = 0; m_pres = 1; end
          end
        end
      end else if (m_st == 3 || m_st == 5) begin
        if (!above) begin m_st = 1; m_ms = 0; end
      end else if (m_st == 4) begin
        if (above) m_st = 5;
      end
      m_prev_en = chg_en;
    end
  end

  always @(posedge clk) begin
    #2;
    chk("R3", "det_en", det_en, m_st == 1);
    chk("R4", "pre_en", pre_en, m_st == 2);
    chk("R7", "flt_en", flt_en, m_st == 4);
    chk("R6", "fault", fault, (m_st == 4) || (m_st == 5));
    chk("R3", "present", present, m_pres);
    chk("R5", "absent", absent, m_abs);
    if (present) seen_present++;
    if (absent) seen_absent++;
  end

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    done = 1'b1; cyc(1); done = 1'b0;
  endtask

  task automatic pulse_fault();
    tfault = 1'b1; cyc(1); tfault = 1'b0;
  endtask

  task automatic run_all();
    cyc(3);
    chk("R1", "reset enables", {det_en, pre_en, flt_en}, 0);
    chk("R1", "reset flags", {fault, present, absent}, 0);
    rst_n = 1'b1; chg_en = 1'b1; cyc(3);

    // R2/R3: sink test finds a cell
    above = 0; below = 0; pulse_done(); cyc(1);
    chk("R2", "det_en after start", det_en, 1);
    cyc(22);
    chk("R3", "present count", seen_present, 1);

    // R4: sink pulls low, push shows a cell
    below = 1; pulse_done(); cyc(21);
    chk("R4", "pre_en during second window", pre_en, 1);
    below = 0; cyc(22);
    chk("R4", "present count", seen_present, 2);

    // R5: both tests pass -> absent, then reprobe on decay
    below = 1; pulse_done(); cyc(21);
    above = 1; below = 0; cyc(22);
    chk("R5", "absent count", seen_absent, 1);
    chk("R5", "no current while rearmed", {det_en, pre_en, flt_en}, 0);
    cyc(5);
    above = 0; cyc(2);
    chk("R5", "reprobe det_en", det_en, 1);
    cyc(22);
    chk("R5", "present after reprobe", seen_present, 3);

    // R10: early comparator activity ignored
    pulse_done();
    for (int i = 0; i < 12; i++) begin below = 1'($urandom % 2); cyc(1); end
    below = 0; cyc(12);
    chk("R10", "present count", seen_present, 4);
    chk("R10", "absent count", seen_absent, 1);

    // R7: timeout with battery low
    above = 0; pulse_fault(); cyc(4);
    chk("R7", "flt_en on", flt_en, 1);
    above = 1; cyc(3);
    chk("R7", "flt_en off after rise", flt_en, 0);
    chk("R6", "fault held", fault, 1);
    above = 0; cyc(2);
    chk("R6", "fault cleared on decay", fault, 0);
    chk("R6", "probe after recovery", det_en, 1);
    cyc(22);
    chk("R6", "present after recovery", seen_present, 5);

    // R6 + R8: timeout with battery high, then enable toggle
    above = 1; pulse_fault(); cyc(3);
    chk("R6", "fault held high", fault, 1);
    chk("R6", "no current in wait", {det_en, pre_en, flt_en}, 0);
    chg_en = 0; cyc(2); chg_en = 1; cyc(2);
    chk("R8", "fault cleared by enable edge", fault, 0);
    above = 0; cyc(3);
    chk("R8", "idle stays idle", det_en, 0);

    // R8: reset in the middle of a probe
    pulse_done(); cyc(5);
    rst_n = 0; cyc(2);
    chk("R8", "reset clears probe", {det_en, pre_en, fault}, 0);
    rst_n = 1; cyc(5);
    chk("R9", "no extra verdicts", seen_present + seen_absent, 6);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule